// File: doc/BRIEF.md
# Bus-Mapped I/O Port with Write-Masked Macrocells

This block is one 8-pin general-purpose I/O port driven by a simple CPU-side register interface: a 3-bit address, a write strobe, a read strobe, write data and registered read data. Software can sample the pin levels through a two-flop synchronizer. It can write and read back an output data value and a per-pin direction bit. It can also read the effective output enable of each pin. That enable is the OR of the direction bit and an external per-pin enable term, which arrives from surrounding logic as a plain input.

The port also holds a bank of output macrocell flip-flops, whose outputs leave the block on their own bus. A mask register blocks software loads into those flip-flops bit by bit. A drive register selects open-drain operation for the upper half of the pins and carries slew-rate selects for the lower half. The slew selects are passed out unchanged.

Register addresses: 0 pin level (read-only), 1 output data, 2 direction, 3 macrocells, 4 mask, 5 effective enable (read-only), 6 drive, 7 unmapped. A write takes effect on the clock edge where the write strobe is high. A read captures the addressed value into the read data register on the edge where the read strobe is high, so it is visible one cycle later.

Top module: `gpio_mc_port`

## Requirements
- R1: After reset, output data, direction, macrocells, mask and drive are all zero, the read data is zero, and every pin is a tri-state input (pin_oe all zero, mc_out zero, slew_sel zero).
- R2: Reading address 0 returns pin_in as sampled through two flops. A pin level held for two clock edges is returned by a read that is captured on the third edge. A read captured on the first edge after a change returns the old level.
- R3: Address 1 (output data) stores any written byte and returns it unchanged on read.
- R4: In push-pull mode, pin_oe[i] = direction[i] OR pt_oe[i], and pin_out[i] equals output data bit i. Address 2 (direction) reads back as written.
- R5: Address 5 returns direction OR pt_oe bit by bit, sampled on the read edge.
- R6: A write to address 3 loads macrocell bit i from write data bit i only where mask bit i is 0. Masked bits keep their value. mc_out and reads of address 3 show the macrocell flip-flops.
- R7: Address 4 (mask) is writable and readable, and it resets to zero so that all macrocell loads are unblocked after reset.
- R8: Address 6 (drive) reads back as written. For pins 7..4, drive bit i = 1 selects open-drain mode: pin_out[i] = 0 and pin_oe[i] = effective enable AND NOT output data bit i. Pins 3..0 are always push-pull, and slew_sel equals drive bits 3..0.
- R9: Writes to addresses 0, 5 and 7 change no register, and a read of address 7 returns zero.
- R10: bus_rdata changes only on an edge where bus_rd is high, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin levels from the pads |
| pt_oe | input | 8 | External per-pin output-enable term |
| pin_out | output | 8 | Value driven to each pad |
| pin_oe | output | 8 | Per-pad driver enable |
| mc_out | output | 8 | Output macrocell flip-flop values |
| slew_sel | output | 4 | Slew-rate selects for pins 3..0 |

## Verification
A wrong internal register shows up on the combinational pad outputs pin_oe, pin_out, mc_out or slew_sel in the cycle right after the faulty write. On the bus, it shows up one cycle after a read strobe. A macrocell bit that loads through a set mask bit, or that fails to load through a clear one, shows on mc_out at the next edge. A synchronizer with the wrong depth moves the pin-level read by a cycle, which a read placed right at the latency boundary exposes. Open-drain errors appear only when drive, output data and enable are combined, so those four are swept together.

// File: rtl/gpio_mc_pkg.sv
package gpio_mc_pkg;

    localparam int PORT_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_PIN    = 3'd0,
        RA_DOUT   = 3'd1,
        RA_DIR    = 3'd2,
        RA_MCELL  = 3'd3,
        RA_MASK   = 3'd4,
        RA_OEN    = 3'd5,
        RA_DRIVE  = 3'd6,
        RA_NONE   = 3'd7
    } port_reg_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= d_async;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_mc_pkg::*;
#(
    parameter int WIDTH = PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  port_reg_e         wr_sel,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  dout_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  mcell_q,
    output logic [WIDTH-1:0]  mask_q,
    output logic [WIDTH-1:0]  drive_q
);
    // Masked load: blocked bits keep their value, open bits take the write.
    logic [WIDTH-1:0] mcell_load;

    always_comb begin
        mcell_load = (mcell_q & mask_q) | (wdata & ~mask_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q  <= '0;
            dir_q   <= '0;
            mcell_q <= '0;
            mask_q  <= '0;
            drive_q <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                RA_DOUT:  dout_q  <= wdata;
                RA_DIR:   dir_q   <= wdata;
                RA_MCELL: mcell_q <= mcell_load;
                RA_MASK:  mask_q  <= wdata;
                RA_DRIVE: drive_q <= wdata;
                RA_PIN, RA_OEN, RA_NONE: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
    parameter int WIDTH    = 8,
    parameter int OD_FIRST = 4
) (
    input  logic [WIDTH-1:0] dout,
    input  logic [WIDTH-1:0] oe_eff,
    input  logic [WIDTH-1:0] drive,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        if (i >= OD_FIRST) begin : g_od_capable
            always_comb begin
                if (drive[i]) begin
                    pad_out[i] = 1'b0;
                    pad_oe[i]  = oe_eff[i] & ~dout[i];
                end else begin
                    pad_out[i] = dout[i];
                    pad_oe[i]  = oe_eff[i];
                end
            end
        end else begin : g_push_pull
            always_comb begin
                pad_out[i] = dout[i];
                pad_oe[i]  = oe_eff[i];
            end
        end
    end
endmodule

// File: rtl/gpio_mc_port.sv
module gpio_mc_port
    import gpio_mc_pkg::*;
#(
    parameter int WIDTH     = PORT_W,
    parameter int OD_FIRST  = PORT_W / 2,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [WIDTH-1:0]     bus_wdata,
    output logic [WIDTH-1:0]     bus_rdata,
    input  logic [WIDTH-1:0]     pin_in,
    input  logic [WIDTH-1:0]     pt_oe,
    output logic [WIDTH-1:0]     pin_out,
    output logic [WIDTH-1:0]     pin_oe,
    output logic [WIDTH-1:0]     mc_out,
    output logic [OD_FIRST-1:0]  slew_sel
);
    localparam int SLEW_W = OD_FIRST;

    port_reg_e        sel;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] dout_q, dir_q, mcell_q, mask_q, drive_q;
    logic [WIDTH-1:0] oe_eff;
    logic [WIDTH-1:0] rd_mux;

    assign sel = port_reg_e'(bus_addr);

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_sel  (sel),
        .wdata   (bus_wdata),
        .dout_q  (dout_q),
        .dir_q   (dir_q),
        .mcell_q (mcell_q),
        .mask_q  (mask_q),
        .drive_q (drive_q)
    );

    assign oe_eff = dir_q | pt_oe;

    gpio_pad_ctl #(.WIDTH(WIDTH), .OD_FIRST(OD_FIRST)) u_pad (
        .dout    (dout_q),
        .oe_eff  (oe_eff),
        .drive   (drive_q),
        .pad_out (pin_out),
        .pad_oe  (pin_oe)
    );

    always_comb begin
        unique case (sel)
            RA_PIN:   rd_mux = pin_sync;
            RA_DOUT:  rd_mux = dout_q;
            RA_DIR:   rd_mux = dir_q;
            RA_MCELL: rd_mux = mcell_q;
            RA_MASK:  rd_mux = mask_q;
            RA_OEN:   rd_mux = oe_eff;
            RA_DRIVE: rd_mux = drive_q;
            RA_NONE:  rd_mux = '0;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign mc_out   = mcell_q;
    assign slew_sel = drive_q[SLEW_W-1:0];
endmodule

// File: rtl/gpio_mc_port_chk.sv
module gpio_mc_port_chk #(
    parameter int WIDTH    = 8,
    parameter int OD_FIRST = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] bus_rdata,
    input logic [WIDTH-1:0] pt_oe,
    input logic [WIDTH-1:0] pin_out,
    input logic [WIDTH-1:0] pin_oe,
    input logic [WIDTH-1:0] mc_out,
    input logic [WIDTH-1:0] mask_q,
    input logic [WIDTH-1:0] dir_q,
    input logic [WIDTH-1:0] dout_q,
    input logic [WIDTH-1:0] drive_q
);
    localparam logic [WIDTH-1:0] OD_PINS = ~((WIDTH)'((1 << OD_FIRST) - 1));

    logic mc_wr;
    assign mc_wr = bus_wr && (bus_addr == 3'd3);

    a_r6_masked_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mc_wr |=> ((mc_out & $past(mask_q)) == ($past(mc_out) & $past(mask_q))));

    a_r6_open_bits_load: assert property (@(posedge clk) disable iff (!rst_n)
        mc_wr |=> ((mc_out & ~$past(mask_q)) == ($past(bus_wdata) & ~$past(mask_q))));

    a_r6_mc_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_wr |=> $stable(mc_out));

    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    a_r5_enable_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd5) |=> (bus_rdata == $past(dir_q | pt_oe)));

    a_r8_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & pin_out & drive_q & OD_PINS) == '0));

    a_r4_oe_covers_pt: assert property (@(posedge clk) disable iff (!rst_n)
        (((dir_q | pt_oe) & ~(drive_q & OD_PINS) & ~pin_oe) == '0));

    a_r9_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 3'd0 || bus_addr == 3'd5 || bus_addr == 3'd7))
        |=> ($stable(dout_q) && $stable(dir_q) && $stable(mask_q) && $stable(drive_q)));
endmodule

bind gpio_mc_port gpio_mc_port_chk #(.WIDTH(WIDTH), .OD_FIRST(OD_FIRST)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pt_oe     (pt_oe),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .mc_out    (mc_out),
    .mask_q    (mask_q),
    .dir_q     (dir_q),
    .dout_q    (dout_q),
    .drive_q   (drive_q)
);

// File: tb/tb_gpio_mc_port.sv
module tb_gpio_mc_port;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pt_oe = '0;
    logic [7:0] pin_out, pin_oe, mc_out;
    logic [3:0] slew_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_mc_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pt_oe(pt_oe), .pin_out(pin_out), .pin_oe(pin_oe),
        .mc_out(mc_out), .slew_sel(slew_sel)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] q);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        q = bus_rdata;
    endtask

    function automatic logic [7:0] exp_oe(input logic [7:0] dir, input logic [7:0] pt,
                                          input logic [7:0] d, input logic [7:0] drv);
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = (i >= 4 && drv[i]) ? ((dir[i] | pt[i]) & ~d[i]) : (dir[i] | pt[i]);
        return r;
    endfunction

    function automatic logic [7:0] exp_out(input logic [7:0] d, input logic [7:0] drv);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = (i >= 4 && drv[i]) ? 1'b0 : d[i];
        return r;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] q;
        logic [7:0] mc_model, mask_v, data_v, dir_v, pt_v, d_v, drv_v;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 mc_out", mc_out, 8'h00);
        check("R1 slew_sel", {4'h0, slew_sel}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), q);
            check("R1 reg reset", q, 8'h00);
        end
        check("R1 pin_oe after reset", pin_oe, 8'h00);

        // R2: synchronizer latency
        pin_in = 8'hA5; bus_addr = 3'd0; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R2 read on change edge is old", bus_rdata, 8'h00);
        for (int k = 0; k < 16; k++) begin
            pin_in = 8'(k * 8'd53 + 8'd11);
            @(negedge clk); @(negedge clk);
            rd(3'd0, q);
            check("R2 synced pin read", q, 8'(k * 8'd53 + 8'd11));
        end

        // R3: output data sweep
        for (int v = 0; v < 256; v++) begin
            wr(3'd1, 8'(v));
            rd(3'd1, q);
            check("R3 dout readback", q, 8'(v));
        end

        // R4, R5: push-pull enable and enable readback
        for (int k = 0; k < 32; k++) begin
            dir_v = 8'(k * 8'd37 + 8'd3);
            pt_v  = 8'(k * 8'd91 + 8'd40);
            d_v   = 8'(k * 8'd19 + 8'd77);
            pt_oe = pt_v;
            wr(3'd2, dir_v);
            wr(3'd1, d_v);
            check("R4 pin_oe push-pull", pin_oe, dir_v | pt_v);
            check("R4 pin_out push-pull", pin_out, d_v);
            rd(3'd2, q);
            check("R4 dir readback", q, dir_v);
            rd(3'd5, q);
            check("R5 enable out", q, dir_v | pt_v);
        end

        // R7, R6: mask and masked macrocell loads
        mc_model = 8'h00;
        for (int m = 0; m < 16; m++) begin
            mask_v = 8'(m * 8'd23 + ((m == 0) ? 8'd0 : 8'd5));
            wr(3'd4, mask_v);
            rd(3'd4, q);
            check("R7 mask readback", q, mask_v);
            for (int j = 0; j < 8; j++) begin
                data_v = 8'(j * 8'd71 + m * 8'd13 + 8'd1);
                wr(3'd3, data_v);
                mc_model = (mc_model & mask_v) | (data_v & ~mask_v);
                check("R6 mc_out masked load", mc_out, mc_model);
                rd(3'd3, q);
                check("R6 macrocell readback", q, mc_model);
            end
        end
        wr(3'd4, 8'h00);
        wr(3'd3, 8'h3C);
        check("R7 zero mask loads all", mc_out, 8'h3C);
        wr(3'd4, 8'hFF);
        wr(3'd3, 8'hC3);
        check("R6 full mask blocks all", mc_out, 8'h3C);

        // R8: drive register and open-drain behaviour
        for (int k = 0; k < 64; k++) begin
            drv_v = 8'(k * 8'd45 + 8'd9);
            dir_v = 8'(k * 8'd29 + 8'd100);
            pt_v  = 8'(k * 8'd83);
            d_v   = 8'(k * 8'd61 + 8'd17);
            pt_oe = pt_v;
            wr(3'd6, drv_v);
            wr(3'd2, dir_v);
            wr(3'd1, d_v);
            check("R8 pin_oe", pin_oe, exp_oe(dir_v, pt_v, d_v, drv_v));
            check("R8 pin_out", pin_out, exp_out(d_v, drv_v));
            check("R8 slew_sel", {4'h0, slew_sel}, {4'h0, drv_v[3:0]});
            rd(3'd6, q);
            check("R8 drive readback", q, drv_v);
        end

        // R9: read-only and unmapped writes
        wr(3'd1, 8'h5A); wr(3'd2, 8'h0F); wr(3'd4, 8'h81); wr(3'd6, 8'hF0);
        pin_in = 8'h66; pt_oe = 8'h00;
        repeat (3) @(negedge clk);
        wr(3'd0, 8'hFF); wr(3'd5, 8'hFF); wr(3'd7, 8'hFF);
        rd(3'd0, q); check("R9 pin after write", q, 8'h66);
        rd(3'd1, q); check("R9 dout kept", q, 8'h5A);
        rd(3'd2, q); check("R9 dir kept", q, 8'h0F);
        rd(3'd4, q); check("R9 mask kept", q, 8'h81);
        rd(3'd5, q); check("R9 enable kept", q, 8'h0F);
        rd(3'd6, q); check("R9 drive kept", q, 8'hF0);
        rd(3'd7, q); check("R9 unmapped reads zero", q, 8'h00);
        check("R9 mc_out kept", mc_out, 8'h3C);

        // R10: read data holds without a read strobe
        rd(3'd1, q);
        wr(3'd1, 8'hC7);
        pin_in = 8'h99;
        repeat (4) @(negedge clk);
        check("R10 rdata holds", bus_rdata, 8'h5A);
        rd(3'd1, q);
        check("R10 rdata updates on read", q, 8'hC7);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule